// File: doc/BRIEF.md
# Word-wide hardware monitor register unit

This block holds a 32-entry register set for a board health monitor. A host reaches it through an indexed request channel with 16-bit data. Most entries are byte registers. A read of a byte register returns the byte in both halves of the word. A fixed window of entries returns true 16-bit values.

A few indexes are live sensor views. When one of them is read, the unit builds the result from the sensor codes present on its inputs at that moment: one temperature code, two fan counts and four voltage codes. Writes pass through a mask that depends on the register. One configuration bit, when written as 1, puts the whole set back to its power-on contents.

Requests use a valid/ready channel. Read data comes back on a second valid/ready channel that holds one response. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only when no response is waiting, or when the waiting response is being taken in that same cycle. A response stays valid, with unchanged data, until the host raises `rsp_ready`. Writes return no response.

Top module: `hwmon_regs`

## Requirements
- R1: After reset, or after a soft reset, these entries read as follows: 0x00 and 0x01 read 0x8080, 0x05 reads 0xC7C7, 0x06 reads 0xC2C2, 0x08 reads 0x6464, 0x09 to 0x0C read 0xDAC5, and 0x0F reads 0xF8F8. Every other stored entry reads 0x0000.
- R2: Only the low 5 bits of `req_index` select the entry. The upper 3 bits have no effect.
- R3: For indexes 0x07 to 0x0C the read data is the full 16-bit value. For every other index, bits [15:8] of the read data equal bits [7:0].
- R4: Index 0x04 reads (`temp_code` + 119) mod 256.
- R5: Index 0x07 reads fan 0's code in bits [15:8] and fan 1's code in bits [7:0]. A fan code is the input count shifted right by a select field taken from entry 0x0F: bits [7:6] for fan 0 and bits [5:4] for fan 1. The result is limited to the range 1 to 255. A count of 0 gives a code of 0.
- R6: Index 0x14 reads `volt0_code`+13, 0x13 reads `volt1_code`+13, 0x0D reads `volt2_code`+13, and 0x15 reads `volt3_code`+13. Each sum saturates at 0xFF.
- R7: A write to 0x03 stores data&0xFC. A write to 0x0F stores data&0xF8. A write to 0x11 stores data&0x7F. A write to 0x07 to 0x0C stores all 16 bits. A write to any other entry stores the low byte only.
- R8: A write to 0x03 with data bit 7 set returns every entry to its R1 value, including entry 0x03, which reads 0x0000 afterwards.
- R9: Writes to the live indexes 0x04, 0x07, 0x0D, 0x13, 0x14 and 0x15 do not change what those indexes read. A write to 0x0A also copies its low byte into the hidden stored entry behind 0x13.
- R10: `req_ready` follows the acceptance rule given above. A response held under back-pressure keeps its data stable. An accepted write leaves `rsp_valid` low in the next cycle.
- R11: A read accepted in the cycle right after a write to the same entry returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 8 | Register index (low 5 bits used) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read data |
| temp_code | input | 8 | Converted temperature code |
| fan0_count | input | 16 | Fan 0 count at divisor 1 |
| fan1_count | input | 16 | Fan 1 count at divisor 1 |
| volt0_code | input | 8 | Voltage code shown at 0x14 |
| volt1_code | input | 8 | Voltage code shown at 0x13 |
| volt2_code | input | 8 | Voltage code shown at 0x0D |
| volt3_code | input | 8 | Voltage code shown at 0x15 |

## Verification
The read composition is tested with several input patterns, and each one separates a different fault:
- Stored byte entries, word entries and live entries are all read, so a faulty duplication or an incorrect word window shows up.
- Temperature codes both below and above the wrap point show whether the offset is taken modulo 256.
- Fan counts are chosen to hit the upper clamp, the lower clamp, the zero case and an in-range value. They are read under two different select settings, which exposes swapped select fields or swapped fan halves.
- Voltage codes near the top of the range show whether the offset saturates or wraps.
- Masked writes, writes to live views and a soft reset are each followed by reads. These show whether the wrong bits were kept, whether a live view was overwritten, and whether any entry escaped the reset.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

  localparam int unsigned IDX_BITS = 5;
  localparam int unsigned NUM_REGS = 1 << IDX_BITS;

  typedef logic [IDX_BITS-1:0] reg_idx_t;

  localparam reg_idx_t IX_ID0     = 5'h00;
  localparam reg_idx_t IX_ID1     = 5'h01;
  localparam reg_idx_t IX_CFG     = 5'h03;
  localparam reg_idx_t IX_TEMP    = 5'h04;
  localparam reg_idx_t IX_LIM_A   = 5'h05;
  localparam reg_idx_t IX_LIM_B   = 5'h06;
  localparam reg_idx_t IX_FAN     = 5'h07;
  localparam reg_idx_t IX_FANLIM  = 5'h08;
  localparam reg_idx_t IX_WORD_LO = 5'h07;
  localparam reg_idx_t IX_WORD_HI = 5'h0C;
  localparam reg_idx_t IX_MIRSRC  = 5'h0A;
  localparam reg_idx_t IX_VOLT2   = 5'h0D;
  localparam reg_idx_t IX_FANDIV  = 5'h0F;
  localparam reg_idx_t IX_MASK7F  = 5'h11;
  localparam reg_idx_t IX_VOLT1   = 5'h13;
  localparam reg_idx_t IX_VOLT0   = 5'h14;
  localparam reg_idx_t IX_VOLT3   = 5'h15;

  localparam int unsigned CFG_INIT_BIT = 7;

  function automatic logic is_word(input reg_idx_t i);
    return (i >= IX_WORD_LO) && (i <= IX_WORD_HI);
  endfunction

  function automatic logic [15:0] reset_value(input reg_idx_t i);
    logic [15:0] v;
    case (i)
      IX_ID0, IX_ID1:         v = 16'h0080;
      IX_LIM_A:               v = 16'h00C7;
      IX_LIM_B:               v = 16'h00C2;
      IX_FANLIM:              v = 16'h6464;
      5'h09, 5'h0A, 5'h0B, 5'h0C: v = 16'hDAC5;
      IX_FANDIV:              v = 16'h00F8;
      default:                v = 16'h0000;
    endcase
    return v;
  endfunction

  function automatic logic [15:0] masked_write(input reg_idx_t i, input logic [15:0] d);
    logic [15:0] v;
    if (is_word(i))          v = d;
    else if (i == IX_CFG)    v = {8'h00, d[7:0] & 8'hFC};
    else if (i == IX_FANDIV) v = {8'h00, d[7:0] & 8'hF8};
    else if (i == IX_MASK7F) v = {8'h00, d[7:0] & 8'h7F};
    else                     v = {8'h00, d[7:0]};
    return v;
  endfunction

endpackage

// File: rtl/hwmon_regfile.sv
module hwmon_regfile
  import hwmon_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  reg_idx_t                         wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  logic soft_init;
  assign soft_init = wr_en && (wr_idx == IX_CFG) && wr_data[CFG_INIT_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    localparam reg_idx_t MY_IDX = reg_idx_t'(g);
    logic hit;
    logic mirror_hit;
    assign hit = wr_en && (wr_idx == MY_IDX);
    if (MY_IDX == IX_VOLT1) begin : g_mirror
      assign mirror_hit = wr_en && (wr_idx == IX_MIRSRC);
    end else begin : g_plain
      assign mirror_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || soft_init) begin
        regs_q[g] <= reset_value(MY_IDX);
      end else if (hit) begin
        regs_q[g] <= masked_write(MY_IDX, wr_data);
      end else if (mirror_hit) begin
        regs_q[g] <= {{BYTE_W{1'b0}}, wr_data[BYTE_W-1:0]};
      end
    end
  end

  // R8: soft reset brings configuration and divisor entries back
  p_soft_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_init |=> (regs_q[IX_CFG] == '0) && (regs_q[IX_FANDIV] == 16'h00F8)
                  && (regs_q[IX_LIM_A] == 16'h00C7));

  // R7: divisor entry never keeps its low three bits
  p_fandiv_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == IX_FANDIV)) |=> (regs_q[IX_FANDIV][2:0] == 3'b000));

  // R7: byte entries keep an empty upper half
  p_byte_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_word(wr_idx) && !soft_init) |=> (regs_q[$past(wr_idx)][DATA_W-1:BYTE_W] == '0));

endmodule

// File: rtl/hwmon_fan_scale.sv
module hwmon_fan_scale #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [SEL_W-1:0]  sel,
  output logic [CODE_W-1:0] code
);

  localparam logic [CNT_W-1:0] CODE_MAX = CNT_W'((1 << CODE_W) - 1);

  logic [CNT_W-1:0] shifted;

  always_comb begin
    shifted = count >> sel;
    if (count == '0)            code = '0;
    else if (shifted == '0)     code = CODE_W'(1);
    else if (shifted > CODE_MAX) code = '1;
    else                        code = shifted[CODE_W-1:0];
  end

  // R5: a running fan never reads as stopped, a stopped one always does
  p_fan_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) == (count == '0));

  // R5: the code never exceeds the undivided count
  p_fan_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> (CNT_W'(code) <= count));

endmodule

// File: rtl/hwmon_read_mux.sv
module hwmon_read_mux
  import hwmon_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned N_VOLT   = 4,
  parameter int unsigned TEMP_OFS = 119,
  parameter int unsigned VOLT_OFS = 13
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  reg_idx_t                         rd_idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
  input  logic [CODE_W-1:0]                temp_code,
  input  logic [1:0][CODE_W-1:0]           fan_code,
  input  logic [N_VOLT-1:0][CODE_W-1:0]    volt_code,
  output logic [DATA_W-1:0]                rd_word
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  function automatic logic [CODE_W-1:0] sat_add(input logic [CODE_W-1:0] c);
    logic [CODE_W:0] s;
    s = {1'b0, c} + (CODE_W+1)'(VOLT_OFS);
    return s[CODE_W] ? '1 : s[CODE_W-1:0];
  endfunction

  logic [BYTE_W-1:0] byte_val;

  always_comb begin
    byte_val = regs_q[rd_idx][BYTE_W-1:0];
    case (rd_idx)
      IX_TEMP:  byte_val = temp_code + CODE_W'(TEMP_OFS);
      IX_VOLT0: byte_val = sat_add(volt_code[0]);
      IX_VOLT1: byte_val = sat_add(volt_code[1]);
      IX_VOLT2: byte_val = sat_add(volt_code[2]);
      IX_VOLT3: byte_val = sat_add(volt_code[3]);
      default:  ;
    endcase
    if (rd_idx == IX_FAN)      rd_word = {fan_code[0], fan_code[1]};
    else if (is_word(rd_idx))  rd_word = regs_q[rd_idx];
    else                       rd_word = {byte_val, byte_val};
  end

  // R6: offset voltage never reads below the raw code
  p_volt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IX_VOLT0) |-> (rd_word[CODE_W-1:0] >= volt_code[0]));

  // R5: fan view is built from the two scalers in fixed halves
  p_fan_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == IX_FAN) |-> (rd_word[DATA_W-1:BYTE_W] == fan_code[0]));

endmodule

// File: rtl/hwmon_regs.sv
module hwmon_regs
  import hwmon_pkg::*;
#(
  parameter int unsigned REQ_IDX_W = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FAN_CNT_W = 16,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned TEMP_OFS  = 119,
  parameter int unsigned VOLT_OFS  = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [REQ_IDX_W-1:0] req_index,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [CODE_W-1:0]    temp_code,
  input  logic [FAN_CNT_W-1:0] fan0_count,
  input  logic [FAN_CNT_W-1:0] fan1_count,
  input  logic [CODE_W-1:0]    volt0_code,
  input  logic [CODE_W-1:0]    volt1_code,
  input  logic [CODE_W-1:0]    volt2_code,
  input  logic [CODE_W-1:0]    volt3_code
);

  localparam int unsigned N_FAN  = 2;
  localparam int unsigned N_VOLT = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned BYTE_W = DATA_W / 2;

  logic                            accept;
  reg_idx_t                        idx;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [N_FAN-1:0][FAN_CNT_W-1:0] fan_cnt;
  logic [N_FAN-1:0][CODE_W-1:0]    fan_code;
  logic [N_VOLT-1:0][CODE_W-1:0]   volt_code;
  logic [DATA_W-1:0]               rd_word;
  reg_idx_t                        rsp_idx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign idx       = req_index[IDX_BITS-1:0];
  assign fan_cnt   = {fan1_count, fan0_count};
  assign volt_code = {volt3_code, volt2_code, volt1_code, volt0_code};

  hwmon_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && req_write),
    .wr_idx  (idx),
    .wr_data (req_wdata),
    .regs_q  (regs_q)
  );

  for (genvar f = 0; f < N_FAN; f++) begin : g_fan
    hwmon_fan_scale #(
      .CNT_W  (FAN_CNT_W),
      .CODE_W (CODE_W),
      .SEL_W  (SEL_W)
    ) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .count (fan_cnt[f]),
      .sel   (regs_q[IX_FANDIV][BYTE_W-1-SEL_W*f -: SEL_W]),
      .code  (fan_code[f])
    );
  end

  hwmon_read_mux #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .N_VOLT   (N_VOLT),
    .TEMP_OFS (TEMP_OFS),
    .VOLT_OFS (VOLT_OFS)
  ) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx),
    .regs_q    (regs_q),
    .temp_code (temp_code),
    .fan_code  (fan_code),
    .volt_code (volt_code),
    .rd_word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_idx   <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
      rsp_idx   <= idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: a stalled response keeps its data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10: a write never produces a response
  p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

  // R3: byte-class responses repeat their low half
  p_byte_dup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !is_word(rsp_idx)) |-> (rsp_rdata[DATA_W-1:BYTE_W] == rsp_rdata[BYTE_W-1:0]));

endmodule

// File: tb/tb_hwmon_regs.sv
module tb_hwmon_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_index = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic [7:0]  temp_code = 8'd30;
  logic [15:0] fan0_count = 16'd450;
  logic [15:0] fan1_count = 16'd900;
  logic [7:0]  volt0_code = 8'd100;
  logic [7:0]  volt1_code = 8'd200;
  logic [7:0]  volt2_code = 8'd246;
  logic [7:0]  volt3_code = 8'd60;

  int total = 0;
  int bad = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  hwmon_regs dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .temp_code(temp_code), .fan0_count(fan0_count), .fan1_count(fan1_count),
    .volt0_code(volt0_code), .volt1_code(volt1_code),
    .volt2_code(volt2_code), .volt3_code(volt3_code)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fan_exp(input logic [15:0] c, input int sh);
    logic [15:0] s;
    s = c >> sh;
    if (c == 0) return 8'd0;
    if (s == 0) return 8'd1;
    if (s > 255) return 8'd255;
    return s[7:0];
  endfunction

  function automatic logic [7:0] volt_exp(input logic [7:0] c);
    int s;
    s = int'(c) + 13;
    return (s > 255) ? 8'hFF : 8'(s);
  endfunction

  task automatic send(input logic wr, input logic [7:0] ix, input logic [15:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_index = ix;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic wr(input logic [7:0] ix, input logic [15:0] d);
    send(1'b1, ix, d);
  endtask

  task automatic rd(input logic [7:0] ix, input logic [15:0] exp, input string tag);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    send(1'b0, ix, 16'h0000);
  endtask

  // monitor: pops expectations as responses are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R10 unexpected response", rsp_rdata, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 16'h0000, 16'h0000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", {15'd0, rsp_valid}, 16'h0000);
    chk(req_ready == 1'b1, "R10 req_ready after reset", {15'd0, req_ready}, 16'h0001);

    // R1 reset contents
    rd(8'h00, 16'h8080, "R1 idx00");
    rd(8'h01, 16'h8080, "R1 idx01");
    rd(8'h02, 16'h0000, "R1 idx02");
    rd(8'h03, 16'h0000, "R1 idx03");
    rd(8'h05, 16'hC7C7, "R1 idx05");
    rd(8'h06, 16'hC2C2, "R1 idx06");
    rd(8'h08, 16'h6464, "R1 idx08");
    for (int i = 9; i <= 12; i++) rd(8'(i), 16'hDAC5, "R1 R3 word entry");
    rd(8'h0F, 16'hF8F8, "R1 idx0F");
    rd(8'h11, 16'h0000, "R1 idx11");

    // R2 index masking
    rd(8'hE5, 16'hC7C7, "R2 idxE5");
    rd(8'h28, 16'h6464, "R2 idx28");

    // R4 temperature, below and across wrap
    rd(8'h04, {2{8'd30 + 8'd119}}, "R4 temp30");
    temp_code = 8'd200;
    rd(8'h04, {2{8'd200 + 8'd119}}, "R4 temp200");

    // R5 fans at reset divisor select (3,3)
    rd(8'h07, {fan_exp(450, 3), fan_exp(900, 3)}, "R5 fan sel3");
    // R7 masked divisor write then R5 with select (1,1)
    wr(8'h0F, 16'h005F);
    rd(8'h0F, 16'h5858, "R7 R11 idx0F mask");
    rd(8'h07, {fan_exp(450, 1), fan_exp(900, 1)}, "R5 fan sel1 clamp");
    wr(8'h0F, 16'h0060);
    rd(8'h07, {fan_exp(450, 1), fan_exp(900, 2)}, "R5 fan split select");

    // R6 voltages
    rd(8'h14, {2{volt_exp(100)}}, "R6 v0");
    rd(8'h13, {2{volt_exp(200)}}, "R6 v1");
    rd(8'h0D, {2{volt_exp(246)}}, "R6 v2 saturate");
    rd(8'h15, {2{volt_exp(60)}}, "R6 v3");

    // R7 masking
    wr(8'h11, 16'hFFFF);
    rd(8'h11, 16'h7F7F, "R7 idx11");
    wr(8'h02, 16'hABCD);
    rd(8'h02, 16'hCDCD, "R7 R3 idx02 low byte");
    wr(8'h09, 16'h1234);
    rd(8'h09, 16'h1234, "R7 R3 word store");
    wr(8'h03, 16'h007F);
    rd(8'h03, 16'h7C7C, "R7 idx03 mask");

    // R9 live views ignore writes
    wr(8'h14, 16'h0000);
    rd(8'h14, {2{volt_exp(100)}}, "R9 v0 live");
    wr(8'h04, 16'h5555);
    rd(8'h04, {2{8'd200 + 8'd119}}, "R9 temp live");
    wr(8'h07, 16'h0000);
    rd(8'h07, {fan_exp(450, 1), fan_exp(900, 2)}, "R9 fan live");
    wr(8'h0A, 16'h0011);
    rd(8'h0A, 16'h0011, "R9 R11 idx0A");
    rd(8'h13, {2{volt_exp(200)}}, "R9 v1 live after mirror");

    // R8 soft reset
    wr(8'h03, 16'h0080);
    rd(8'h03, 16'h0000, "R8 idx03");
    rd(8'h0F, 16'hF8F8, "R8 idx0F");
    rd(8'h11, 16'h0000, "R8 idx11");
    rd(8'h09, 16'hDAC5, "R8 idx09");
    rd(8'h0A, 16'hDAC5, "R8 idx0A");
    rd(8'h02, 16'h0000, "R8 idx02");

    // R5 clamp corners at select 3
    fan0_count = 16'd1;
    fan1_count = 16'd0;
    rd(8'h07, 16'h0100, "R5 low clamp and stopped");
    fan0_count = 16'd5000;
    fan1_count = 16'd8;
    rd(8'h07, 16'hFF01, "R5 high clamp");

    // R10 back-pressure
    repeat (2) @(negedge clk);
    rsp_ready = 1'b0;
    rd(8'h05, 16'hC7C7, "R10 stalled response");
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && (rsp_rdata == 16'hC7C7), "R10 held data", rsp_rdata, 16'hC7C7);
      chk(!req_ready, "R10 ready low while full", {15'd0, req_ready}, 16'h0000);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(q_exp.size() == 0, "R10 all responses seen", 16'(q_exp.size()), 16'h0000);
    chk(!rsp_valid, "R10 idle after drain", {15'd0, rsp_valid}, 16'h0000);
    finish_run();
  end

endmodule